// File: doc/BRIEF.md
# Hardware Barrier Synchronization Unit

This block lets up to thirteen processing elements of one cluster meet at a hardware barrier. It contains six barrier blades. Each blade holds a participant mask and one arrival bit per element. Each element reaches blades through four private windows. A window carries a valid flag and the number of the blade it is bound to. Each element also has a control register that holds two enables, one for privileged accesses and one for unprivileged accesses.

An element arrives by pulsing its arrival strobe, which names the window and the access level. It then polls its busy output through a window until that output reads 1. When the last masked participant arrives, the blade clears its arrival field and raises the status of every participant in that same update. Each participant's status stays high until that element arrives again.

A single privileged register port configures blades, windows and control registers. It also reads back every register and a read-only identity word. Windows and control registers are to be written with zero by software before use.

Top module: `hwsync_barrier`

## Requirements
- R1: After reset, every blade mask, arrival field, status bit, window, control register and error flag is zero, so `rd_busy` and `err` read zero.
- R2: A privileged write with selector 0 and index b (b below 6) loads blade b's mask from data bits 44:32 and clears that blade's arrival field and all its status bits. A read with selector 0 returns the mask in bits 44:32 and the arrival field in bits 12:0, with bit n standing for element n.
- R3: A permitted arrival by element n, through a valid window bound to blade b whose mask contains n, sets bit n of b's arrival field in the next cycle.
- R4: In the cycle after the arrival bits cover a non-zero mask, the arrival field reads zero and every masked participant's busy status reads 1.
- R5: A participant's status stays 1 until that element arrives again or the blade is configured. Its next arrival clears the status in the following cycle.
- R6: An arrival with `sync_priv`=1 is permitted only if control bit 63 is set. An arrival with `sync_priv`=0 is permitted only if control bit 62 is set. The window must also have its valid bit (bit 63) set.
- R7: An arrival that is not permitted changes no arrival field and sets that element's error flag in the next cycle. The flag stays set until a control write to that element (selector 2), and it stays set if a new denied arrival occurs in the same cycle as that write.
- R8: `rd_busy[n]` is 0 unless the window named by `rd_win` is valid and permitted for the access level given by `rd_priv`.
- R9: A read with selector 3 for element n (n below 13) returns the cluster number (parameter, default 2) in bits 5:4 and n in bits 3:0.
- R10: A write with selector 1 stores the window valid bit from bit 63 and the blade number from bits 2:0, and a read returns them in the same bits. An arrival through a window naming blade 6 or 7 is treated as denied.
- R11: Arrivals from several elements in the same cycle are all recorded, and they complete the barrier if together they cover the mask.
- R12: A blade configuration write in the same cycle as an arrival to that blade takes priority: the arrival is dropped.
- R13: A permitted arrival to a blade whose mask does not include the element changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_we | input | 13 | Per-element arrival strobe |
| sync_win | input | 26 | Per-element window index for arrival (2 bits each) |
| sync_priv | input | 13 | Per-element access level of arrival (1 = privileged) |
| rd_win | input | 26 | Per-element window index for busy polling |
| rd_priv | input | 13 | Per-element access level of polling |
| rd_busy | output | 13 | Per-element busy status read through its window |
| err | output | 13 | Per-element sticky denied-access flag |
| prv_we | input | 1 | Privileged register write strobe |
| prv_sel | input | 2 | Register kind: 0 blade, 1 window, 2 control, 3 identity |
| prv_pe | input | 4 | Element addressed |
| prv_idx | input | 3 | Blade or window index |
| prv_wdata | input | 64 | Privileged write data |
| prv_rdata | output | 64 | Privileged read data (combinational) |

## Verification
The assertions take for granted that reset is held low from time zero through the first edges, and that strobes and indices are stable around each rising edge. They also assume that the element index on the privileged port is interpreted only below 13. The stimulus changes every input one nanosecond after a rising edge. It keeps `prv_pe` in 0..12 while allowing blade indices 6 and 7, so the ignored and denied paths are still exercised. Random traffic sets permissions and windows freely, so denied, out-of-mask and simultaneous arrivals all occur against the behavioural model.

// File: rtl/hwsync_barrier.sv
module hwsync_barrier #(
  parameter int NPE        = 13,
  parameter int NBLADE     = 6,
  parameter int NWIN       = 4,
  parameter int PEW        = 4,
  parameter int CLUSTER_ID = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPE-1:0]      sync_we,
  input  logic [NPE*$clog2(NWIN)-1:0] sync_win,
  input  logic [NPE-1:0]      sync_priv,
  input  logic [NPE*$clog2(NWIN)-1:0] rd_win,
  input  logic [NPE-1:0]      rd_priv,
  output logic [NPE-1:0]      rd_busy,
  output logic [NPE-1:0]      err,
  input  logic                prv_we,
  input  logic [1:0]          prv_sel,
  input  logic [PEW-1:0]      prv_pe,
  input  logic [2:0]          prv_idx,
  input  logic [63:0]         prv_wdata,
  output logic [63:0]         prv_rdata
);
  localparam int WW  = $clog2(NWIN);
  localparam int BW  = $clog2(NBLADE);
  localparam int NB2 = 1 << BW;
  localparam logic [1:0] SEL_BLD = 2'd0, SEL_WIN = 2'd1, SEL_CTL = 2'd2, SEL_ID = 2'd3;

  logic [NBLADE-1:0][NPE-1:0] mask_q, arr_q, stat_q;
  logic                       wv_q [NPE][NWIN];
  logic [BW-1:0]              wb_q [NPE][NWIN];
  logic [NPE-1:0]             cp_q, cu_q, err_q;

  wire  [NBLADE-1:0][NPE-1:0] set_v;
  wire  [NBLADE-1:0]          cfg_hit, done;
  wire  [NPE-1:0][NB2-1:0]    scol;
  wire  [NPE-1:0][BW-1:0]     sblade;
  wire  [NPE-1:0]             s_ok, ctl_hit;

  assign err = err_q;

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    logic [WW-1:0] sw, rw;
    assign sw = sync_win[p*WW +: WW];
    assign rw = rd_win[p*WW +: WW];
    assign sblade[p]  = wb_q[p][sw];
    assign s_ok[p]    = wv_q[p][sw] & (sync_priv[p] ? cp_q[p] : cu_q[p])
                        & ({1'b0, wb_q[p][sw]} < (BW+1)'(NBLADE));
    assign rd_busy[p] = wv_q[p][rw] & (rd_priv[p] ? cp_q[p] : cu_q[p]) & scol[p][wb_q[p][rw]];
    assign ctl_hit[p] = prv_we && (prv_sel == SEL_CTL) && (prv_pe == PEW'(p));

    for (genvar bb = 0; bb < NB2; bb++) begin : g_col
      if (bb < NBLADE) begin : g_real
        assign scol[p][bb]  = stat_q[bb][p];
        assign set_v[bb][p] = sync_we[p] & s_ok[p] & (sblade[p] == BW'(bb)) & mask_q[bb][p];
      end else begin : g_pad
        assign scol[p][bb] = 1'b0;
      end
    end

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[p] && !ctl_hit[p] |=> err_q[p]);
    a_r7_deny: assert property (@(posedge clk) disable iff (!rst_n)
      sync_we[p] && !s_ok[p] |=> err_q[p]);
  end

  for (genvar bb = 0; bb < NBLADE; bb++) begin : g_bl
    assign cfg_hit[bb] = prv_we && (prv_sel == SEL_BLD) && (prv_idx == 3'(bb));
    assign done[bb]    = (|mask_q[bb]) && (((arr_q[bb] | set_v[bb]) & mask_q[bb]) == mask_q[bb]);

    a_r2_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit[bb] |=> (arr_q[bb] == '0) && (stat_q[bb] == '0));
    a_r13_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_q[bb] & ~mask_q[bb]) == '0);

    for (genvar p = 0; p < NPE; p++) begin : g_pp
      a_r4_rise_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[bb][p]) |-> arr_q[bb] == '0);
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[bb][p] && !set_v[bb][p] && !cfg_hit[bb] |=> stat_q[bb][p]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      arr_q  <= '0;
      stat_q <= '0;
      cp_q   <= '0;
      cu_q   <= '0;
      err_q  <= '0;
      for (int p = 0; p < NPE; p++)
        for (int w = 0; w < NWIN; w++) begin
          wv_q[p][w] <= 1'b0;
          wb_q[p][w] <= '0;
        end
    end else begin
      for (int bb = 0; bb < NBLADE; bb++) begin
        if (cfg_hit[bb]) begin
          mask_q[bb] <= prv_wdata[32 +: NPE];
          arr_q[bb]  <= '0;
          stat_q[bb] <= '0;
        end else if (done[bb]) begin
          arr_q[bb]  <= '0;
          stat_q[bb] <= mask_q[bb];
        end else begin
          arr_q[bb]  <= arr_q[bb] | set_v[bb];
          stat_q[bb] <= stat_q[bb] & ~set_v[bb];
        end
      end
      for (int p = 0; p < NPE; p++) begin
        for (int w = 0; w < NWIN; w++)
          if (prv_we && prv_sel == SEL_WIN && prv_pe == PEW'(p) && prv_idx == 3'(w)) begin
            wv_q[p][w] <= prv_wdata[63];
            wb_q[p][w] <= prv_wdata[BW-1:0];
          end
        if (ctl_hit[p]) begin
          cp_q[p] <= prv_wdata[63];
          cu_q[p] <= prv_wdata[62];
        end
        err_q[p] <= (err_q[p] & ~ctl_hit[p]) | (sync_we[p] & ~s_ok[p]);
      end
    end
  end

  always_comb begin
    prv_rdata = '0;
    case (prv_sel)
      SEL_BLD:
        for (int bb = 0; bb < NBLADE; bb++)
          if (prv_idx == 3'(bb)) begin
            prv_rdata[32 +: NPE] = mask_q[bb];
            prv_rdata[0 +: NPE]  = arr_q[bb];
          end
      SEL_WIN:
        for (int p = 0; p < NPE; p++)
          for (int w = 0; w < NWIN; w++)
            if (prv_pe == PEW'(p) && prv_idx == 3'(w)) begin
              prv_rdata[63]     = wv_q[p][w];
              prv_rdata[BW-1:0] = wb_q[p][w];
            end
      SEL_CTL:
        for (int p = 0; p < NPE; p++)
          if (prv_pe == PEW'(p)) begin
            prv_rdata[63] = cp_q[p];
            prv_rdata[62] = cu_q[p];
          end
      SEL_ID:
        if (prv_pe < PEW'(NPE)) begin
          prv_rdata[5:4] = 2'(CLUSTER_ID);
          prv_rdata[3:0] = 4'(prv_pe);
        end
      default: prv_rdata = '0;
    endcase
  end
endmodule

// File: tb/hwsync_barrier_bench.sv
`timescale 1ns/100ps
module hwsync_barrier_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [12:0] sync_we = '0, sync_priv = '0, rd_priv = '0;
  logic [25:0] sync_win = '0, rd_win = '0;
  logic        prv_we = 1'b0;
  logic [1:0]  prv_sel = '0;
  logic [3:0]  prv_pe = '0;
  logic [2:0]  prv_idx = '0;
  logic [63:0] prv_wdata = '0;
  wire  [12:0] rd_busy, err;
  wire  [63:0] prv_rdata;

  hwsync_barrier u_hwsync_barrier (
    .clk(clk), .rst_n(rst_n), .sync_we(sync_we), .sync_win(sync_win), .sync_priv(sync_priv),
    .rd_win(rd_win), .rd_priv(rd_priv), .rd_busy(rd_busy), .err(err),
    .prv_we(prv_we), .prv_sel(prv_sel), .prv_pe(prv_pe), .prv_idx(prv_idx),
    .prv_wdata(prv_wdata), .prv_rdata(prv_rdata));

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int unsigned m_mask[6], m_arr[6], m_stat[6], m_setm[6];
  int unsigned m_err = 0, m_deny = 0, mn = 0;
  bit          m_wv[13][4];
  int          m_wb[13][4];
  bit          m_cp[13], m_cu[13];
  int          mw = 0, mb = 0;
  bit          mok = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 6; b++) begin m_mask[b] = 0; m_arr[b] = 0; m_stat[b] = 0; end
      for (int p = 0; p < 13; p++) begin
        m_cp[p] = 0; m_cu[p] = 0;
        for (int w = 0; w < 4; w++) begin m_wv[p][w] = 0; m_wb[p][w] = 0; end
      end
      m_err = 0;
    end else begin
      m_deny = 0;
      for (int b = 0; b < 6; b++) m_setm[b] = 0;
      for (int p = 0; p < 13; p++)
        if (sync_we[p]) begin
          mw  = int'(sync_win[p*2 +: 2]);
          mb  = m_wb[p][mw];
          mok = m_wv[p][mw] && (sync_priv[p] ? m_cp[p] : m_cu[p]) && mb < 6;
          if (!mok) m_deny |= (1 << p);
          else if (m_mask[mb][p]) m_setm[mb] |= (1 << p);
        end
      for (int b = 0; b < 6; b++) begin
        if (prv_we && prv_sel == 2'd0 && int'(prv_idx) == b) begin
          m_mask[b] = int'(prv_wdata[44:32]); m_arr[b] = 0; m_stat[b] = 0;
        end else begin
          mn = m_arr[b] | m_setm[b];
          if (m_mask[b] != 0 && (mn & m_mask[b]) == m_mask[b]) begin
            m_arr[b] = 0; m_stat[b] = m_mask[b];
          end else begin
            m_arr[b] = mn; m_stat[b] = m_stat[b] & ~m_setm[b];
          end
        end
      end
      if (prv_we && prv_sel == 2'd2 && int'(prv_pe) < 13) m_err &= ~(1 << int'(prv_pe));
      m_err |= m_deny;
      if (prv_we && prv_sel == 2'd1 && int'(prv_pe) < 13 && int'(prv_idx) < 4) begin
        m_wv[int'(prv_pe)][int'(prv_idx)] = prv_wdata[63];
        m_wb[int'(prv_pe)][int'(prv_idx)] = int'(prv_wdata[2:0]);
      end
      if (prv_we && prv_sel == 2'd2 && int'(prv_pe) < 13) begin
        m_cp[int'(prv_pe)] = prv_wdata[63];
        m_cu[int'(prv_pe)] = prv_wdata[62];
      end
    end
  end

  function automatic logic [63:0] exp_rd();
    logic [63:0] r = '0;
    int pe = int'(prv_pe), ix = int'(prv_idx);
    case (prv_sel)
      2'd0: if (ix < 6) r = (64'(m_mask[ix]) << 32) | 64'(m_arr[ix]);
      2'd1: if (pe < 13 && ix < 4) begin r[63] = m_wv[pe][ix]; r[2:0] = 3'(m_wb[pe][ix]); end
      2'd2: if (pe < 13) begin r[63] = m_cp[pe]; r[62] = m_cu[pe]; end
      default: if (pe < 13) r = 64'(32 + pe);
    endcase
    return r;
  endfunction

  function automatic logic [12:0] exp_busy();
    logic [12:0] r = '0;
    for (int p = 0; p < 13; p++) begin
      int w = int'(rd_win[p*2 +: 2]);
      int b = m_wb[p][w];
      if (m_wv[p][w] && (rd_priv[p] ? m_cp[p] : m_cu[p]) && b < 6 && m_stat[b][p]) r[p] = 1'b1;
    end
    return r;
  endfunction

  always @(negedge clk)
    if (rst_n && !finished) begin
      chk("R5/R8 busy vs model", 64'(rd_busy), 64'(exp_busy()));
      chk("R7 err vs model", 64'(err), 64'(m_err[12:0]));
      chk("R2/R10 rdata vs model", prv_rdata, exp_rd());
    end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pw(input logic [1:0] s, input int pe, input int idx, input logic [63:0] d);
    prv_we = 1'b1; prv_sel = s; prv_pe = 4'(pe); prv_idx = 3'(idx); prv_wdata = d;
    tick();
    prv_we = 1'b0;
    #1;
  endtask

  task automatic pr(input logic [1:0] s, input int pe, input int idx);
    prv_sel = s; prv_pe = 4'(pe); prv_idx = 3'(idx);
    #0.2;
  endtask

  task automatic arrive(input logic [12:0] m);
    sync_we = m;
    tick();
    sync_we = '0;
    #1;
  endtask

  localparam logic [63:0] VALID = 64'h8000_0000_0000_0000;
  localparam logic [63:0] UNPRIV = 64'h4000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    chk("R1 busy after reset", 64'(rd_busy), 64'h0);
    chk("R1 err after reset", 64'(err), 64'h0);
    pr(2'd0, 0, 0); chk("R1 blade0 after reset", prv_rdata, 64'h0);
    pr(2'd2, 5, 0); chk("R1 control after reset", prv_rdata, 64'h0);

    for (int p = 0; p < 13; p++) begin
      pw(2'd2, p, 0, 64'h0);
      for (int w = 0; w < 4; w++) pw(2'd1, p, w, 64'h0);
    end

    pr(2'd3, 7, 0);  chk("R9 identity pe7", prv_rdata, 64'h27);
    pr(2'd3, 12, 0); chk("R9 identity pe12", prv_rdata, 64'h2C);

    pw(2'd0, 0, 0, 64'h7 << 32);
    pr(2'd0, 0, 0); chk("R2 blade0 mask readback", prv_rdata, 64'h0000_0007_0000_0000);
    for (int p = 0; p < 3; p++) pw(2'd2, p, 0, UNPRIV);
    pw(2'd1, 0, 1, VALID);
    pw(2'd1, 1, 0, VALID);
    pw(2'd1, 2, 3, VALID);
    pr(2'd1, 2, 3); chk("R10 window readback", prv_rdata, VALID);
    sync_win = 26'b11_00_01; rd_win = 26'b11_00_01;

    arrive(13'b001);
    pr(2'd0, 0, 0); chk("R3 first arrival bit", prv_rdata, 64'h0000_0007_0000_0001);
    chk("R3 no busy yet", 64'(rd_busy[2:0]), 64'h0);
    arrive(13'b010);
    pr(2'd0, 0, 0); chk("R3 second arrival bit", prv_rdata, 64'h0000_0007_0000_0003);
    arrive(13'b100);
    pr(2'd0, 0, 0); chk("R4 arrival field cleared", prv_rdata, 64'h0000_0007_0000_0000);
    chk("R4 all participants busy", 64'(rd_busy[2:0]), 64'h7);
    arrive(13'b001);
    chk("R5 rearrival clears own status", 64'(rd_busy[2:0]), 64'h6);

    rd_priv[1] = 1'b1; #0.2;
    chk("R8 privileged poll without enable", 64'(rd_busy[1]), 64'h0);
    rd_priv[1] = 1'b0; #0.2;

    sync_priv[1] = 1'b1;
    arrive(13'b010);
    chk("R6 privileged arrival denied error", 64'(err[1]), 64'h1);
    pr(2'd0, 0, 0); chk("R7 denied arrival leaves field", prv_rdata, 64'h0000_0007_0000_0001);
    pw(2'd2, 1, 0, 64'hC000_0000_0000_0000);
    chk("R7 control write clears error", 64'(err[1]), 64'h0);
    arrive(13'b010);
    pr(2'd0, 0, 0); chk("R6 privileged arrival accepted", prv_rdata, 64'h0000_0007_0000_0003);
    sync_priv[1] = 1'b0;

    pw(2'd0, 0, 1, 64'h18 << 32);
    pw(2'd2, 5, 0, UNPRIV);
    pw(2'd1, 5, 0, VALID | 64'h1);
    arrive(13'b1_0000_0);
    pr(2'd0, 0, 1); chk("R13 non-member arrival ignored", prv_rdata, 64'h0000_0018_0000_0000);
    chk("R13 no error for non-member", 64'(err[5]), 64'h0);

    pw(2'd2, 3, 0, UNPRIV);
    pw(2'd2, 4, 0, UNPRIV);
    pw(2'd1, 3, 2, VALID | 64'h1);
    pw(2'd1, 4, 2, VALID | 64'h1);
    sync_win[7:6] = 2'd2; sync_win[9:8] = 2'd2; rd_win[7:6] = 2'd2; rd_win[9:8] = 2'd2;
    arrive(13'b1_1000);
    pr(2'd0, 0, 1); chk("R11 joint arrival completes", prv_rdata, 64'h0000_0018_0000_0000);
    chk("R11 both busy", 64'(rd_busy[4:3]), 64'h3);

    pw(2'd2, 6, 0, UNPRIV);
    pw(2'd1, 6, 0, VALID | 64'h7);
    arrive(13'b100_0000);
    chk("R10 out-of-range blade denied", 64'(err[6]), 64'h1);
    pw(2'd2, 7, 0, UNPRIV);
    arrive(13'b1000_0000);
    chk("R6 invalid window denied", 64'(err[7]), 64'h1);

    prv_we = 1'b1; prv_sel = 2'd0; prv_idx = 3'd0; prv_wdata = 64'h7 << 32;
    sync_we = 13'b100;
    tick();
    prv_we = 1'b0; sync_we = '0; #1;
    pr(2'd0, 0, 0); chk("R12 config wins over arrival", prv_rdata, 64'h0000_0007_0000_0000);
    chk("R12 no completion", 64'(rd_busy[2:0]), 64'h0);

    arrive(13'b001);
    pw(2'd0, 0, 0, 64'h7 << 32);
    pr(2'd0, 0, 0); chk("R2 config clears pending arrival", prv_rdata, 64'h0000_0007_0000_0000);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      sync_we   = 13'($urandom) & 13'($urandom);
      sync_win  = 26'($urandom);
      sync_priv = 13'($urandom);
      rd_win    = 26'($urandom);
      rd_priv   = 13'($urandom);
      prv_we    = ($urandom % 6) == 0;
      prv_sel   = 2'($urandom);
      prv_pe    = 4'($urandom % 13);
      prv_idx   = 3'($urandom);
      prv_wdata = {$urandom, $urandom};
    end
    @(posedge clk); #1;
    sync_we = '0; prv_we = 1'b0;
    repeat (3) @(posedge clk);
    #1 finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule